// File: doc/BRIEF.md
# Read-Path Power Controller

This block sits on the read side of a memory device. It watches the chip-select, output-enable and address inputs on every clock. From them it decides when the device drives its tri-state data bus. It issues a one-cycle read strobe to the storage array whenever a new read starts, and it reports the power state of the read circuitry.

The block has three power states. It is in standby while the chip is deselected and active while reads are happening. After a configurable number of quiet clock cycles in the active state it falls into a near-standby auto low-power state. While the chip is selected, any address change or control-pin change brings the device straight back to active. The read strobe for that access goes out with the same latency as from the active state, so a wake-up costs no access time. The data bus itself, the array, and current-draw modelling are handled outside the block.

Top module: `rdp_read_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pwr_state` is 2'b00 (standby), `dq_oe` is 0 and `rd_stb` is 0.
- R2: `dq_oe` is 1 in the cycle after a clock edge that sampled `ce_n`=0 and `oe_n`=0. Otherwise it is 0, which leaves the data bus high impedance.
- R3: A clock edge that samples `ce_n`=1 puts `pwr_state` to 2'b00 (standby) from any state, and it clears the idle timer.
- R4: A clock edge that samples `ce_n`=0 after a sample with `ce_n`=1 puts `pwr_state` to 2'b01 (active).
- R5: After `IDLE_CYC` consecutive clock edges in the active state with the chip selected and no wake event, `pwr_state` becomes 2'b10 (auto low-power). It stays there until a wake event occurs or the chip is deselected.
- R6: While selected, a change of `addr` from its previously sampled value puts `pwr_state` to 2'b01, from either active or low-power, and restarts the full idle interval.
- R7: While selected, a change of `oe_n` in either direction acts as a wake event, just as an address change does, and also restarts the idle interval.
- R8: `rd_stb` is 1 for exactly the cycle after an edge that samples `ce_n`=0 and `oe_n`=0 together with a wake event (chip-select fall, address change or `oe_n` change). The latency is the same whether the prior state was active or low-power.
- R9: While `ce_n`=1, changes on `addr` and `oe_n` have no effect: `pwr_state` stays 2'b00 and `rd_stb` stays 0.
- R10: `pwr_state` never takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Read address, compared with the previously sampled value |
| dq_oe | output | 1 | Data-bus drive enable (1 = drive, 0 = high impedance) |
| rd_stb | output | 1 | One-cycle read request to the array |
| pwr_state | output | 2 | Power state: 00 standby, 01 active, 10 auto low-power |

## Verification
Every output is registered once. A stimulus applied before clock edge k therefore shows on `dq_oe`, `rd_stb` and `pwr_state` just after edge k, and the bench samples one time unit after each rising edge. The fall into low-power is due exactly `IDLE_CYC` edges after the last wake event. The directed steps count those edges one by one, checking active on edges 1 to `IDLE_CYC`-1 and low-power on the last. A long pseudo-random sweep uses sparse input changes so that idle runs of every length up to and past the limit occur. It compares every cycle against an arithmetic model in the bench that updates on the same edge.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'b00,
    PS_ACTIVE  = 2'b01,
    PS_LOWPWR  = 2'b10
  } pwr_e;

  // Both selects low: a read that may drive the bus.
  function automatic logic read_req(input logic ce_n, input logic oe_n);
    return !ce_n && !oe_n;
  endfunction

  // Wake condition: selected and either just selected or any pin moved.
  function automatic logic wake_cond(input logic ce_n, input logic ce_prev,
                                     input logic addr_moved, input logic oe_moved);
    return !ce_n && (ce_prev || addr_moved || oe_moved);
  endfunction

endpackage

// File: rtl/rdp_edge_det.sv
module rdp_edge_det #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wake_evt
);
  import rdp_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic              oe_q;
  logic              ce_q;
  logic              addr_moved;
  logic              oe_moved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      oe_q   <= 1'b1;
      ce_q   <= 1'b1;
    end else begin
      addr_q <= addr;
      oe_q   <= oe_n;
      ce_q   <= ce_n;
    end
  end

  assign addr_moved = (addr != addr_q);
  assign oe_moved   = (oe_n != oe_q);
  assign wake_evt   = wake_cond(ce_n, ce_q, addr_moved, oe_moved);

endmodule

// File: rtl/rdp_idle_tmr.sv
module rdp_idle_tmr #(
  parameter int IDLE_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && !clr && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || expire)   cnt <= '0;
    else if (run)             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/rdp_fsm.sv
module rdp_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wake_evt,
  input  logic              expire,
  output rdp_pkg::pwr_e     state
);
  import rdp_pkg::*;

  pwr_e state_d;

  always_comb begin
    state_d = state;
    if (ce_n)                              state_d = PS_STANDBY;
    else if (wake_evt)                     state_d = PS_ACTIVE;
    else if (state == PS_ACTIVE && expire) state_d = PS_LOWPWR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_STANDBY;
    else        state <= state_d;
  end

endmodule

// File: rtl/rdp_read_ctrl.sv
module rdp_read_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int IDLE_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic              rd_stb,
  output logic [1:0]        pwr_state
);
  import rdp_pkg::*;

  logic wake_evt;
  logic tmr_expire;
  logic tmr_clr;
  logic tmr_run;
  pwr_e state;

  rdp_edge_det #(.ADDR_W(ADDR_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .wake_evt(wake_evt)
  );

  assign tmr_clr = ce_n || wake_evt;
  assign tmr_run = (state == PS_ACTIVE);

  rdp_idle_tmr #(.IDLE_CYC(IDLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .expire(tmr_expire)
  );

  rdp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wake_evt(wake_evt),
    .expire(tmr_expire), .state(state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      rd_stb <= 1'b0;
    end else begin
      dq_oe  <= read_req(ce_n, oe_n);
      rd_stb <= read_req(ce_n, oe_n) && wake_evt;
    end
  end

  assign pwr_state = state;

endmodule

// File: rtl/rdp_read_chk.sv
module rdp_read_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       wake_evt,
  input logic       tmr_expire,
  input logic       dq_oe,
  input logic       rd_stb,
  input logic [1:0] pwr_state
);

  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |=> dq_oe);

  a_r2_hiz_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !dq_oe);

  a_r3_deselect_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (pwr_state == 2'b00));

  a_r4_wake_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && wake_evt) |=> (pwr_state == 2'b01));

  a_r5_idle_lowpwr: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !wake_evt && tmr_expire) |=> (pwr_state == 2'b10));

  a_r5_lowpwr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && !ce_n && !wake_evt) |=> (pwr_state == 2'b10));

  a_r8_strobe_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> dq_oe);

  a_r9_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !rd_stb);

  a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);

endmodule

bind rdp_read_ctrl rdp_read_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .wake_evt(wake_evt), .tmr_expire(tmr_expire),
  .dq_oe(dq_oe), .rd_stb(rd_stb), .pwr_state(pwr_state)
);

// File: tb/tb_rdp_read_ctrl.sv
module tb_rdp_read_ctrl;
  localparam int AW   = 4;
  localparam int IDLE = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          dq_oe;
  logic          rd_stb;
  logic [1:0]    pwr_state;

  int tests = 0;
  int fails = 0;

  // bench model state
  logic          m_pce, m_poe;
  logic [AW-1:0] m_paddr;
  logic [1:0]    m_st;
  int            m_quiet;
  logic          m_dq, m_stb;

  always #2.5 clk = ~clk;

  rdp_read_ctrl #(.ADDR_W(AW), .IDLE_CYC(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
    .dq_oe(dq_oe), .rd_stb(rd_stb), .pwr_state(pwr_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pce = 1'b1; m_poe = 1'b1; m_paddr = '0;
    m_st = 2'b00; m_quiet = 0; m_dq = 1'b0; m_stb = 1'b0;
  endtask

  // Apply inputs, advance one edge, compare with arithmetic model.
  task automatic apply(input logic c, input logic o, input logic [AW-1:0] a);
    bit evt;
    string sreq;
    ce_n = c; oe_n = o; addr = a;
    evt = !c && (m_pce || (a != m_paddr) || (o != m_poe));
    m_dq  = !c && !o;
    m_stb = !c && !o && evt;
    if (c) begin
      m_st = 2'b00; m_quiet = 0; sreq = "R3";
    end else if (evt) begin
      m_st = 2'b01; m_quiet = 0; sreq = "R4";
    end else begin
      sreq = "R5";
      if (m_st == 2'b01) begin
        m_quiet++;
        if (m_quiet == IDLE) begin m_st = 2'b10; m_quiet = 0; end
      end
    end
    m_pce = c; m_poe = o; m_paddr = a;
    @(posedge clk); #1;
    chk(pwr_state == m_st, sreq, pwr_state, m_st);
    chk(dq_oe == m_dq, "R2", dq_oe, m_dq);
    chk(rd_stb == m_stb, "R8", rd_stb, m_stb);
    chk(pwr_state != 2'b11, "R10", pwr_state, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic c, o;
    logic [AW-1:0] a;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk(pwr_state == 2'b00, "R1", pwr_state, 0);
    chk(dq_oe == 1'b0, "R1", dq_oe, 0);
    chk(rd_stb == 1'b0, "R1", rd_stb, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(pwr_state == 2'b00 && !dq_oe && !rd_stb, "R1", pwr_state, 0);

    // R9: deselected, pins wiggle, nothing happens
    apply(1'b1, 1'b1, 4'd3);
    chk(pwr_state == 2'b00 && !rd_stb, "R9", pwr_state, 0);
    apply(1'b1, 1'b0, 4'd5);
    chk(pwr_state == 2'b00 && !rd_stb && !dq_oe, "R9", rd_stb, 0);

    // R4/R8: select with output enabled
    apply(1'b0, 1'b0, 4'd5);
    chk(pwr_state == 2'b01, "R4", pwr_state, 1);
    chk(rd_stb == 1'b1, "R8", rd_stb, 1);
    // R5: exact idle count
    for (int i = 1; i < IDLE; i++) begin
      apply(1'b0, 1'b0, 4'd5);
      chk(pwr_state == 2'b01, "R5", pwr_state, 1);
      chk(rd_stb == 1'b0, "R8", rd_stb, 0);
    end
    apply(1'b0, 1'b0, 4'd5);
    chk(pwr_state == 2'b10, "R5", pwr_state, 2);
    apply(1'b0, 1'b0, 4'd5);
    chk(pwr_state == 2'b10, "R5", pwr_state, 2);

    // R6/R8: address change wakes, strobe with same latency
    apply(1'b0, 1'b0, 4'd6);
    chk(pwr_state == 2'b01, "R6", pwr_state, 1);
    chk(rd_stb == 1'b1 && dq_oe == 1'b1, "R8", rd_stb, 1);

    // R7: oe change restarts the interval
    for (int i = 0; i < IDLE - 2; i++) apply(1'b0, 1'b0, 4'd6);
    apply(1'b0, 1'b1, 4'd6);
    chk(pwr_state == 2'b01 && !dq_oe && !rd_stb, "R7", pwr_state, 1);
    for (int i = 1; i < IDLE; i++) begin
      apply(1'b0, 1'b1, 4'd6);
      chk(pwr_state == 2'b01, "R7", pwr_state, 1);
    end
    apply(1'b0, 1'b1, 4'd6);
    chk(pwr_state == 2'b10, "R7", pwr_state, 2);
    apply(1'b0, 1'b0, 4'd6);
    chk(pwr_state == 2'b01 && rd_stb, "R7", pwr_state, 1);

    // R3: deselect from active and from low-power
    apply(1'b1, 1'b0, 4'd6);
    chk(pwr_state == 2'b00 && !dq_oe, "R3", pwr_state, 0);
    apply(1'b0, 1'b1, 4'd6);
    for (int i = 0; i < IDLE; i++) apply(1'b0, 1'b1, 4'd6);
    chk(pwr_state == 2'b10, "R5", pwr_state, 2);
    apply(1'b1, 1'b1, 4'd6);
    chk(pwr_state == 2'b00, "R3", pwr_state, 0);

    // Sweep: sparse pseudo-random changes
    lf = 16'hACE1;
    c = 1'b1; o = 1'b1; a = 4'd6;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[3:0] == 4'd0)  c = ~c;
      if (lf[7:5] == 3'd0)  a = lf[11:8];
      if (lf[14:12] == 3'd0) o = ~o;
      apply(c, o, a);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule